// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block performs single 16-bit reads and writes into the internal control space of a PHY that is reached through a 32-bit command word and a 32-bit status word. A client presents an address, write data and a direction, and pulses a start input. The block then runs the handshake steps in order. Each strobe is held on the command word until the PHY raises its acknowledge. The strobe is then withdrawn, and the block waits for the acknowledge to drop before it moves on.

A write runs three strobed steps: address capture, data capture and the write itself. A read runs two: address capture and the read strobe. Each wait for the acknowledge has its own time budget of `POLL_LIMIT` polls spaced `POLL_GAP` clock cycles apart. If that budget runs out, the operation is abandoned, the command word returns to zero and the completion is flagged as a timeout. The client sees a one-cycle done pulse. The timeout flag and the read data stay valid until the next completion.

Top module: `phy_creg_master`

## Requirements
- R1: After reset, and whenever no operation is running, `phy_cmd` is zero, `busy` is low, `rsp_done` is low, and both `rsp_timeout` and `rsp_rdata` are zero until the first completion.
- R2: The command word carries the 16-bit value in bits [17:2] and four strobes: write at bit 0, read at bit 1, capture-data at bit 18 and capture-address at bit 19. No more than one strobe is high at a time. Bits [31:20] are always zero.
- R3: Address step. For exactly two cycles the address sits in [17:2] with no strobe. Capture-address is then added and held, with the address, until the acknowledge is seen high. After that the address stays without a strobe until the acknowledge is seen low.
- R4: A write follows the address step with a data step of the same shape that uses capture-data. It then raises the write strobe with the data in [17:2] until the acknowledge is high, and keeps the data without a strobe until the acknowledge is low.
- R5: A read follows the address step with a command word that holds only the read strobe, with [17:2] zero. It latches status bits [15:0] on the cycle the acknowledge is high. It then drives zero until the acknowledge is low, and returns the latched value on `rsp_rdata`.
- R6: The acknowledge is status bit 16. Status bits [31:17] have no effect.
- R7: If the awaited acknowledge level does not appear within `POLL_LIMIT*POLL_GAP` cycles of a wait step, the operation ends at once with `rsp_done` and `rsp_timeout` high and `phy_cmd` back to zero. Counted from the start edge, an address-capture stall ends after 3+`POLL_LIMIT*POLL_GAP` edges.
- R8: A completion with a timeout returns `rsp_rdata` equal to zero, even for a read.
- R9: `rsp_done` is high for a single cycle per operation. A start seen while `busy` is high is ignored and leaves no trace in the PHY.
- R10: The time budget restarts at every wait step, so an operation whose steps each take just under the budget completes without a timeout, even though its total time is several budgets long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start pulse, accepted only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address inside the PHY |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An operation is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Last completion was abandoned on a timeout |
| rsp_rdata | output | 16 | Read data of the last completion, zero on a write or a timeout |
| phy_cmd | output | 32 | Command word to the PHY |
| phy_status | input | 32 | Status word from the PHY (acknowledge and read data) |

## Verification
The hardest case to reach is a timeout at a chosen step, and in particular a timeout on the release side, where the PHY has acknowledged and then never lets go. The bench PHY model has a per-strobe stall mask and a "stuck acknowledge" switch. These let a single step be held while all earlier steps complete normally. The model's acknowledge latency is also adjustable up to just below the budget, which drives every step of one operation close to expiry to show that the budget restarts at each step.

// File: rtl/creg_pkg.sv
// Shared constants and types for the PHY control-register master.
// Assumes a 32-bit command word with a 16-bit value field.
package creg_pkg;

    localparam int unsigned CMD_W        = 32;
    localparam int unsigned VAL_W        = 16;
    localparam int unsigned VAL_LSB      = 2;
    localparam int unsigned BIT_WR       = 0;
    localparam int unsigned BIT_RD       = 1;
    localparam int unsigned BIT_CAP_DATA = 18;
    localparam int unsigned BIT_CAP_ADDR = 19;
    localparam int unsigned BIT_ACK      = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SET,
        ST_ADDR_CAP,
        ST_ADDR_REL,
        ST_DATA_SET,
        ST_DATA_CAP,
        ST_DATA_REL,
        ST_WR_STB,
        ST_WR_REL,
        ST_RD_STB,
        ST_RD_REL
    } creg_state_e;

    // Assemble a command word from a value and the four strobes.
    function automatic logic [CMD_W-1:0] make_cmd(
        input logic [VAL_W-1:0] val,
        input logic             wr,
        input logic             rd,
        input logic             capd,
        input logic             capa
    );
        logic [CMD_W-1:0] w;
        w = '0;
        w[VAL_LSB +: VAL_W] = val;
        w[BIT_WR]           = wr;
        w[BIT_RD]           = rd;
        w[BIT_CAP_DATA]     = capd;
        w[BIT_CAP_ADDR]     = capa;
        return w;
    endfunction

endpackage

// File: rtl/creg_poll_timer.sv
// Per-step time budget. Counts polls of POLL_GAP cycles each and flags
// expiry on the last cycle of poll POLL_LIMIT. The sequencer clears it on
// every step change. Assumes POLL_LIMIT >= 1 and POLL_GAP >= 1.
module creg_poll_timer #(
    parameter int unsigned POLL_LIMIT = 200,
    parameter int unsigned POLL_GAP   = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int unsigned PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

    logic          tick;
    logic [PW-1:0] poll_q;

    generate
        if (POLL_GAP > 1) begin : g_gap
            localparam int unsigned GW = $clog2(POLL_GAP);
            localparam logic [GW-1:0] GAP_LAST = GW'(POLL_GAP - 1);
            logic [GW-1:0] gap_q;

            // Cycle counter within one poll interval.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    gap_q <= '0;
                end else if (run) begin
                    gap_q <= (gap_q == GAP_LAST) ? '0 : gap_q + 1'b1;
                end
            end

            assign tick = run && (gap_q == GAP_LAST);
        end else begin : g_nogap
            assign tick = run;
        end
    endgenerate

    // Count completed polls, saturating at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            poll_q <= '0;
        end else if (tick && (poll_q != POLL_LAST)) begin
            poll_q <= poll_q + 1'b1;
        end
    end

    assign expired = tick && (poll_q == POLL_LAST);

endmodule

// File: rtl/creg_sequencer.sv
// Step sequencer for one register access. Latches the request when idle,
// walks the address, data, write or read steps, waits for the acknowledge
// to reach the awaited level and abandons the access when the timer
// expires. Assumes the acknowledge input is already synchronous to clk.
module creg_sequencer
    import creg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write,
    input  logic [VAL_W-1:0]  addr,
    input  logic [VAL_W-1:0]  wdata,
    input  logic              ack,
    input  logic [VAL_W-1:0]  status_lo,
    input  logic              tmr_expired,
    output creg_state_e       state,
    output logic [VAL_W-1:0]  op_addr,
    output logic [VAL_W-1:0]  op_data,
    output logic              tmr_clr,
    output logic              tmr_run,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [VAL_W-1:0]  rdata
);
    creg_state_e      state_q, state_d;
    logic             setup_q;
    logic             op_wr_q;
    logic [VAL_W-1:0] op_addr_q, op_data_q, rd_buf_q;
    logic             done_q, tmo_q;
    logic [VAL_W-1:0] rdata_q;
    logic             want_high, waiting, met, finish_ok, abort;

    // Classify the current step: which acknowledge level it waits for.
    always_comb begin
        waiting   = 1'b0;
        want_high = 1'b0;
        unique case (state_q)
            ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB: begin
                waiting   = 1'b1;
                want_high = 1'b1;
            end
            ST_ADDR_REL, ST_DATA_REL, ST_WR_REL, ST_RD_REL: begin
                waiting   = 1'b1;
            end
            default: ;
        endcase
    end

    assign met       = waiting && (ack == want_high);
    assign abort     = waiting && !met && tmr_expired;
    assign finish_ok = met && ((state_q == ST_WR_REL) || (state_q == ST_RD_REL));

    // Next-step selection.
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (start) state_d = ST_ADDR_SET;
                ST_ADDR_SET: if (setup_q) state_d = ST_ADDR_CAP;
                ST_ADDR_CAP: if (met) state_d = ST_ADDR_REL;
                ST_ADDR_REL: if (met) state_d = op_wr_q ? ST_DATA_SET : ST_RD_STB;
                ST_DATA_SET: if (setup_q) state_d = ST_DATA_CAP;
                ST_DATA_CAP: if (met) state_d = ST_DATA_REL;
                ST_DATA_REL: if (met) state_d = ST_WR_STB;
                ST_WR_STB:   if (met) state_d = ST_WR_REL;
                ST_WR_REL:   if (met) state_d = ST_IDLE;
                ST_RD_STB:   if (met) state_d = ST_RD_REL;
                ST_RD_REL:   if (met) state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Step register and two-cycle setup counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            setup_q <= 1'b0;
        end else begin
            state_q <= state_d;
            setup_q <= ((state_q == ST_ADDR_SET) || (state_q == ST_DATA_SET)) && !setup_q;
        end
    end

    // Request capture, only while idle, so later starts are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q   <= 1'b0;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else if ((state_q == ST_IDLE) && start) begin
            op_wr_q   <= write;
            op_addr_q <= addr;
            op_data_q <= wdata;
        end
    end

    // Read data latch on the acknowledge of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf_q <= '0;
        end else if ((state_q == ST_RD_STB) && met) begin
            rd_buf_q <= status_lo;
        end
    end

    // Completion pulse, timeout flag and returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= finish_ok || abort;
            if (finish_ok || abort) begin
                tmo_q   <= abort;
                rdata_q <= (abort || op_wr_q) ? '0 : rd_buf_q;
            end
        end
    end

    assign tmr_run = waiting;
    assign tmr_clr = !waiting || (state_d != state_q);
    assign state   = state_q;
    assign op_addr = op_addr_q;
    assign op_data = op_data_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign timeout = tmo_q;
    assign rdata   = rdata_q;

endmodule

// File: rtl/creg_cmd_encode.sv
// Decodes the current step into the command word: which value sits in the
// field and which strobe, if any, is raised. Purely combinational from
// registered step and operands, so the word changes only after a clock edge.
module creg_cmd_encode
    import creg_pkg::*;
(
    input  creg_state_e       state,
    input  logic [VAL_W-1:0]  op_addr,
    input  logic [VAL_W-1:0]  op_data,
    output logic [CMD_W-1:0]  cmd
);
    // Map step to field value and strobe.
    always_comb begin
        unique case (state)
            ST_ADDR_SET, ST_ADDR_REL: cmd = make_cmd(op_addr, 1'b0, 1'b0, 1'b0, 1'b0);
            ST_ADDR_CAP:              cmd = make_cmd(op_addr, 1'b0, 1'b0, 1'b0, 1'b1);
            ST_DATA_SET, ST_DATA_REL,
            ST_WR_REL:                cmd = make_cmd(op_data, 1'b0, 1'b0, 1'b0, 1'b0);
            ST_DATA_CAP:              cmd = make_cmd(op_data, 1'b0, 1'b0, 1'b1, 1'b0);
            ST_WR_STB:                cmd = make_cmd(op_data, 1'b1, 1'b0, 1'b0, 1'b0);
            ST_RD_STB:                cmd = make_cmd('0,      1'b0, 1'b1, 1'b0, 1'b0);
            default:                  cmd = '0;
        endcase
    end

endmodule

// File: rtl/phy_creg_master.sv
// Top of the PHY control-register master. Joins the step sequencer, the
// per-step poll timer and the command encoder. Assumes phy_status is
// synchronous to clk; the budget per wait step is POLL_LIMIT*POLL_GAP cycles.
module phy_creg_master
    import creg_pkg::*;
#(
    parameter int unsigned POLL_LIMIT = 200,
    parameter int unsigned POLL_GAP   = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        rsp_done,
    output logic        rsp_timeout,
    output logic [15:0] rsp_rdata,
    output logic [31:0] phy_cmd,
    input  logic [31:0] phy_status
);
    creg_state_e      state;
    logic [VAL_W-1:0] op_addr, op_data;
    logic             tmr_clr, tmr_run, tmr_expired;
    logic             unused_status;

    assign unused_status = ^phy_status[CMD_W-1:BIT_ACK+1];

    creg_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_start),
        .write       (req_write),
        .addr        (req_addr),
        .wdata       (req_wdata),
        .ack         (phy_status[BIT_ACK]),
        .status_lo   (phy_status[VAL_W-1:0]),
        .tmr_expired (tmr_expired),
        .state       (state),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .tmr_clr     (tmr_clr),
        .tmr_run     (tmr_run),
        .busy        (busy),
        .done        (rsp_done),
        .timeout     (rsp_timeout),
        .rdata       (rsp_rdata)
    );

    creg_poll_timer #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    creg_cmd_encode u_enc (
        .state   (state),
        .op_addr (op_addr),
        .op_data (op_data),
        .cmd     (phy_cmd)
    );

endmodule

// File: rtl/creg_master_chk.sv
// Protocol checker for phy_creg_master, attached by bind. Observes ports only.
module creg_master_chk (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        rsp_done,
    input  logic        rsp_timeout,
    input  logic [15:0] rsp_rdata,
    input  logic [31:0] phy_cmd,
    input  logic [31:0] phy_status
);
    // Idle means a quiet command word.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (phy_cmd == 32'h0));

    // At most one strobe at a time.
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({phy_cmd[19], phy_cmd[18], phy_cmd[1], phy_cmd[0]}) <= 1);

    // Unused upper command bits stay low.
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd[31:20] == 12'h0);

    // Capture-address only drops after an acknowledge or on abandonment.
    assert_capa_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_cmd[19]) |-> ($past(phy_status[16]) || rsp_timeout));

    // Write strobe only drops after an acknowledge or on abandonment.
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_cmd[0]) |-> ($past(phy_status[16]) || rsp_timeout));

    // Read strobe travels alone.
    assert_rd_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_cmd[1] |-> (phy_cmd == 32'h2));

    // A timeout never returns data.
    assert_tmo_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_timeout) |-> (rsp_rdata == 16'h0));

    // Completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind phy_creg_master creg_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .rsp_rdata   (rsp_rdata),
    .phy_cmd     (phy_cmd),
    .phy_status  (phy_status)
);

// File: tb/phy_creg_master_test.sv
// Directed bench with a behavioural PHY model (latency, stall mask, stuck ack).
module phy_creg_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 4;
    localparam int GAP = 3;
    localparam int BUDGET = LIM * GAP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_done, rsp_timeout;
    logic [15:0] rsp_rdata;
    logic [31:0] phy_cmd, phy_status;

    int n_chk = 0;
    int n_fail = 0;
    int proto_err = 0;

    // PHY model controls: {cap-addr, cap-data, write, read}
    int       lat = 1;
    logic [3:0] stall = 4'b0;
    logic     stick = 1'b0;

    logic        ack;
    int          cnt;
    logic [15:0] rd_out, lat_a, lat_d;
    logic [15:0] mem [16];
    logic [31:0] prev1, prev2;
    logic        strobe, stalled;

    phy_creg_master #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
        .phy_cmd(phy_cmd), .phy_status(phy_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Noise in status bits [31:17] must not matter (R6).
    assign phy_status = {15'h2AAA, ack, rd_out};
    assign strobe  = phy_cmd[19] | phy_cmd[18] | phy_cmd[1] | phy_cmd[0];
    assign stalled = (phy_cmd[19] & stall[3]) | (phy_cmd[18] & stall[2]) |
                     (phy_cmd[0] & stall[1]) | (phy_cmd[1] & stall[0]);

    // Behavioural PHY with protocol observation.
    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; cnt <= 0; rd_out <= '0; lat_a <= '0; lat_d <= '0;
            prev1 <= '0; prev2 <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else begin
            prev1 <= phy_cmd;
            prev2 <= prev1;
            if (phy_cmd[19] && !prev1[19] &&
                !(prev1 == (phy_cmd & ~32'h80000) && prev2 == prev1)) proto_err++;
            if (phy_cmd[18] && !prev1[18] &&
                !(prev1 == (phy_cmd & ~32'h40000) && prev2 == prev1)) proto_err++;
            if (phy_cmd[1] && !prev1[1] && phy_cmd != 32'h2) proto_err++;
            if (phy_cmd[0] && !prev1[0] && phy_cmd[17:2] != prev1[17:2]) proto_err++;
            if (strobe) begin
                if (!ack && !stalled) begin
                    if (cnt >= lat) begin
                        ack <= 1'b1;
                        if (phy_cmd[19]) lat_a <= phy_cmd[17:2];
                        if (phy_cmd[18]) lat_d <= phy_cmd[17:2];
                        if (phy_cmd[0]) begin
                            mem[lat_a[3:0]] <= lat_d;
                            if (phy_cmd[17:2] != lat_d) proto_err++;
                        end
                        if (phy_cmd[1]) rd_out <= mem[lat_a[3:0]];
                    end else begin
                        cnt <= cnt + 1;
                    end
                end
            end else begin
                cnt <= 0;
                if (ack && !stick) ack <= 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output bit tmo, output int cyc);
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_start = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        rd = rsp_rdata;
        tmo = rsp_timeout;
        @(negedge clk);
        check(rsp_done == 1'b0, "R9 done pulse width", {31'b0, rsp_done}, 32'h0);
        check(phy_cmd == 32'h0 && !busy, "R1 idle after op", phy_cmd, 32'h0);
    endtask

    task automatic t_reset();
        check(phy_cmd == 32'h0, "R1 cmd reset", phy_cmd, 32'h0);
        check(!busy && !rsp_done && !rsp_timeout, "R1 flags reset",
              {29'b0, busy, rsp_done, rsp_timeout}, 32'h0);
        check(rsp_rdata == 16'h0, "R1 rdata reset", {16'b0, rsp_rdata}, 32'h0);
    endtask

    task automatic t_write_read();
        logic [15:0] rd; bit tmo; int cyc;
        lat = 0; do_op(1'b1, 16'h1003, 16'hBEEF, rd, tmo, cyc);
        check(!tmo && rd == 16'h0, "R4 write completes", {15'b0, tmo, rd}, 32'h0);
        lat = 2; do_op(1'b1, 16'h0007, 16'h1234, rd, tmo, cyc);
        lat = 1; do_op(1'b1, 16'h000C, 16'hC5A1, rd, tmo, cyc);
        lat = 2; do_op(1'b0, 16'h1003, 16'h0, rd, tmo, cyc);
        check(!tmo && rd == 16'hBEEF, "R5 read back 3", {15'b0, tmo, rd}, 32'hBEEF);
        lat = 0; do_op(1'b0, 16'h0007, 16'hFFFF, rd, tmo, cyc);
        check(rd == 16'h1234, "R6 read back 7", {16'b0, rd}, 32'h1234);
        do_op(1'b0, 16'h000C, 16'h0, rd, tmo, cyc);
        check(rd == 16'hC5A1, "R2 field placement read C", {16'b0, rd}, 32'hC5A1);
        check(proto_err == 0, "R3 step shapes", proto_err, 0);
    endtask

    task automatic t_timeout_addr();
        logic [15:0] rd; bit tmo; int cyc;
        lat = 0; stall = 4'b1000;
        do_op(1'b1, 16'h0002, 16'h7777, rd, tmo, cyc);
        check(tmo, "R7 addr stall timeout", {31'b0, tmo}, 32'h1);
        check(cyc == 3 + BUDGET, "R7 addr stall cycles", cyc, 3 + BUDGET);
        stall = 4'b0;
        do_op(1'b0, 16'h0002, 16'h0, rd, tmo, cyc);
        check(!tmo && rd == 16'h0, "R7 abandoned write left no data", {15'b0, tmo, rd}, 32'h0);
    endtask

    task automatic t_timeout_read();
        logic [15:0] rd; bit tmo; int cyc;
        lat = 0; stall = 4'b0001;
        do_op(1'b0, 16'h0007, 16'h0, rd, tmo, cyc);
        check(tmo && rd == 16'h0, "R8 read timeout zero", {15'b0, tmo, rd}, 32'h10000);
        stall = 4'b0;
    endtask

    task automatic t_stuck_ack();
        logic [15:0] rd; bit tmo; int cyc;
        lat = 0; stick = 1'b1;
        do_op(1'b0, 16'h0007, 16'h0, rd, tmo, cyc);
        check(tmo, "R7 release-side timeout", {31'b0, tmo}, 32'h1);
        stick = 1'b0;
        repeat (3) @(negedge clk);
        do_op(1'b0, 16'h0007, 16'h0, rd, tmo, cyc);
        check(!tmo && rd == 16'h1234, "R7 recovers after stuck ack", {15'b0, tmo, rd}, 32'h1234);
    endtask

    task automatic t_slow();
        logic [15:0] rd; bit tmo; int cyc;
        lat = BUDGET - 3;
        do_op(1'b1, 16'h0009, 16'h4242, rd, tmo, cyc);
        check(!tmo, "R10 slow write no timeout", {31'b0, tmo}, 32'h0);
        check(cyc > 2 * BUDGET, "R10 total exceeds budget", cyc, 2 * BUDGET);
        do_op(1'b0, 16'h0009, 16'h0, rd, tmo, cyc);
        check(!tmo && rd == 16'h4242, "R10 slow read", {15'b0, tmo, rd}, 32'h4242);
        lat = 0;
    endtask

    task automatic t_busy_ignore();
        logic [15:0] rd; bit tmo; int cyc; int dones;
        lat = 1;
        do_op(1'b1, 16'h0006, 16'h1111, rd, tmo, cyc);
        @(negedge clk);
        req_start = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'hAAAA;
        @(negedge clk);
        req_start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy, "R9 busy during op", {31'b0, busy}, 32'h1);
        req_start = 1'b1; req_addr = 16'h0006; req_wdata = 16'hBBBB;
        @(negedge clk);
        req_start = 1'b0;
        dones = 0;
        for (int i = 0; i < 80; i++) begin
            if (rsp_done) dones++;
            @(negedge clk);
        end
        check(dones == 1, "R9 one done for two starts", dones, 1);
        do_op(1'b0, 16'h0006, 16'h0, rd, tmo, cyc);
        check(rd == 16'h1111, "R9 ignored start left reg", {16'b0, rd}, 32'h1111);
        do_op(1'b0, 16'h0005, 16'h0, rd, tmo, cyc);
        check(rd == 16'hAAAA, "R9 accepted op written", {16'b0, rd}, 32'hAAAA);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_timeout_addr();
        t_timeout_read();
        t_stuck_ack();
        t_slow();
        t_busy_ignore();
        check(proto_err == 0, "R4 protocol over run", proto_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule